// File: doc/BRIEF.md
# Read-Modify-Write Bus Lock Generator

This block drives an active-low lock line. Bus arbiters watch that line and hold off any other master, such as a DMA engine or a second processor, while the core is part-way through an atomic read-modify-write on memory. The instruction sequencer describes each bus cycle to the block. The description carries an opcode class, the index of the cycle within the current instruction, the total number of cycles in that instruction, and whether the cycle is a read. The block registers its decision, so the lock level for a cycle appears on the clock edge that follows the cycle's description.

The lock covers a fixed tail of the instruction: its final three cycles. In that tail the operand is read, modified and written back. A window opens only if its first cycle is a read. Once open, the lock holds through the modify cycle and the write, and it releases on the next instruction's first cycle. Interrupt entry drops the lock and keeps it dropped for the rest of that window. Accumulator-only forms never lock.

Top module: `rmw_bus_lock`

## Requirements
- R1: `mem_lock_n` goes high as soon as `rst_n` goes low, and the block returns to normal operation only after a synchronous release of two clock edges.
- R2: The lock is active low, and the level for a described cycle appears one clock edge after the description is presented.
- R3: For the locking classes the lock is low for exactly the cycles with index `cyc_total-3` through `cyc_total-1`, and never for more than three consecutive cycles. The locking classes are 2 (memory shift or rotate), 3 (memory increment or decrement), 4 (test-and-set or test-and-reset bits) and 5 (set or clear a single memory bit).
- R4: Classes 0 (other), 1 (accumulator shift, rotate, increment or decrement), 6 and 7 never lock.
- R5: A window locks only if its first cycle is a read (`bus_rd`=1). If that cycle is a write, the lock stays high for the whole instruction.
- R6: Once low, the lock stays low through the remaining window cycles, including writes. It goes high for a description with `cyc_idx`=0, so it never spans two instructions.
- R7: When `irq_entry` is high the lock for that cycle is high, and the lock stays high for the rest of that instruction's window.
- R8: When `cyc_total` is 3 or less, no lock is produced.
- R9: Every write cycle shown under the lock is preceded by a read cycle in the same contiguous lock run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 3 | Opcode class of the current instruction (encoding in R3, R4) |
| cyc_idx | input | CYC_W | Index of the described cycle within the instruction, from 0 |
| cyc_total | input | CYC_W | Number of cycles in the current instruction |
| bus_rd | input | 1 | Described cycle is a read (1) or a write (0) |
| irq_entry | input | 1 | Described cycle belongs to an interrupt entry sequence |
| mem_lock_n | output | 1 | Registered active-low bus lock |

## Verification
The bound checker evaluates several conditions on every cycle. A lock may begin only after a read description. Interrupt entry, non-locking classes and a first-cycle description each force the lock high. A lock run may end only after the last cycle or an interrupt, may not exceed three cycles, and may not show a write before a read inside the run. The bench's scenarios must show the timing itself: the exact cycle a lock opens for each class, the suppressed window when the first tail cycle is a write, the short-instruction case, back-to-back locked instructions, and the asynchronous drop on reset in the middle of a window.

// File: rtl/rmw_lock_pkg.sv
package rmw_lock_pkg;

  localparam int OPC_W       = 3;
  localparam int NUM_CLASSES = 1 << OPC_W;

  typedef enum logic [OPC_W-1:0] {
    OPC_OTHER       = 3'd0,
    OPC_ACC_RMW     = 3'd1,
    OPC_MEM_SHIFT   = 3'd2,
    OPC_MEM_INCDEC  = 3'd3,
    OPC_MEM_TESTBIT = 3'd4,
    OPC_MEM_BITOP   = 3'd5,
    OPC_RSVD6       = 3'd6,
    OPC_RSVD7       = 3'd7
  } opc_class_e;

  // Classes that perform a memory read-modify-write (R3)
  localparam logic [NUM_CLASSES-1:0] DEFAULT_LOCK_MASK =
    (NUM_CLASSES'(1) << OPC_MEM_SHIFT)   |
    (NUM_CLASSES'(1) << OPC_MEM_INCDEC)  |
    (NUM_CLASSES'(1) << OPC_MEM_TESTBIT) |
    (NUM_CLASSES'(1) << OPC_MEM_BITOP);

  typedef struct packed {
    logic in_win;
    logic first;
  } win_info_t;

endpackage

// File: rtl/rmw_rst_sync.sv
module rmw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rmw_class_decode.sv
module rmw_class_decode
  import rmw_lock_pkg::*;
#(
  parameter logic [NUM_CLASSES-1:0] MASK = DEFAULT_LOCK_MASK
) (
  input  logic [OPC_W-1:0] op_class,
  output logic             locks
);

  logic [NUM_CLASSES-1:0] hit;

  for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_cls
    if (MASK[i]) begin : g_on
      assign hit[i] = (op_class == OPC_W'(i));
    end else begin : g_off
      assign hit[i] = 1'b0;
    end
  end

  assign locks = |hit;

endmodule

// File: rtl/rmw_tail_window.sv
module rmw_tail_window
  import rmw_lock_pkg::*;
#(
  parameter int CYC_W = 4,
  parameter int SPAN  = 3
) (
  input  logic [CYC_W-1:0] cyc_idx,
  input  logic [CYC_W-1:0] cyc_total,
  output win_info_t        win
);

  localparam logic [CYC_W-1:0] SPAN_V = CYC_W'(SPAN);

  logic             eligible;
  logic [CYC_W-1:0] start_idx;

  always_comb begin
    eligible   = (cyc_total > SPAN_V);
    start_idx  = cyc_total - SPAN_V;
    win.in_win = eligible && (cyc_idx >= start_idx) && (cyc_idx < cyc_total);
    win.first  = win.in_win && (cyc_idx == start_idx);
  end

endmodule

// File: rtl/rmw_lock_reg.sv
module rmw_lock_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic hold_req,
  input  logic abort,
  output logic lock_n
);

  logic lock_q;
  logic lock_d;
  logic lock_en;

  always_comb begin
    lock_d  = ~abort & (open_req | (hold_req & lock_q));
    lock_en = lock_d ^ lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  assign lock_n = ~lock_q;

endmodule

// File: rtl/rmw_bus_lock.sv
module rmw_bus_lock
  import rmw_lock_pkg::*;
#(
  parameter int                     CYC_W       = 4,
  parameter int                     LOCK_SPAN   = 3,
  parameter logic [NUM_CLASSES-1:0] LOCK_MASK   = DEFAULT_LOCK_MASK,
  parameter int                     SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] op_class,
  input  logic [CYC_W-1:0] cyc_idx,
  input  logic [CYC_W-1:0] cyc_total,
  input  logic             bus_rd,
  input  logic             irq_entry,
  output logic             mem_lock_n
);

  logic      rst_sync_n;
  logic      cls_locks;
  win_info_t win;
  logic      open_req;
  logic      hold_req;

  rmw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rmw_class_decode #(.MASK(LOCK_MASK)) u_dec (
    .op_class (op_class),
    .locks    (cls_locks)
  );

  rmw_tail_window #(.CYC_W(CYC_W), .SPAN(LOCK_SPAN)) u_win (
    .cyc_idx   (cyc_idx),
    .cyc_total (cyc_total),
    .win       (win)
  );

  always_comb begin
    open_req = cls_locks & win.first & bus_rd;
    hold_req = cls_locks & win.in_win & ~win.first;
  end

  rmw_lock_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .open_req (open_req),
    .hold_req (hold_req),
    .abort    (irq_entry),
    .lock_n   (mem_lock_n)
  );

endmodule

// File: rtl/rmw_bus_lock_chk.sv
module rmw_bus_lock_chk #(
  parameter int CYC_W     = 4,
  parameter int LOCK_SPAN = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op_class,
  input logic [CYC_W-1:0] cyc_idx,
  input logic [CYC_W-1:0] cyc_total,
  input logic             bus_rd,
  input logic             irq_entry,
  input logic             mem_lock_n
);

  logic       shown_rd;
  logic       seen_rd;
  logic [7:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shown_rd <= 1'b0;
      seen_rd  <= 1'b0;
      run_cnt  <= '0;
    end else begin
      shown_rd <= bus_rd;
      seen_rd  <= mem_lock_n ? 1'b0 : (seen_rd | shown_rd);
      run_cnt  <= mem_lock_n ? 8'd0 : ((run_cnt == 8'hFF) ? run_cnt : run_cnt + 8'd1);
    end
  end

  a_r1_reset_high: assert property (@(posedge clk) !rst_n |-> mem_lock_n);

  a_r4_nonlock_class: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 3'd0 || op_class == 3'd1 || op_class == 3'd6 || op_class == 3'd7)
    |=> mem_lock_n);

  a_r5_opens_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock_n) |-> $past(bus_rd));

  a_r6_first_cycle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_idx == '0) |=> mem_lock_n);

  a_r6_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_lock_n) |-> ($past(irq_entry) ||
                           (($past(cyc_idx, 2) + 1'b1) == $past(cyc_total, 2))));

  a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |=> mem_lock_n);

  a_r3_max_span: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_lock_n |-> (run_cnt < 8'(LOCK_SPAN)));

  a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_lock_n && !shown_rd) |-> seen_rd);

endmodule

bind rmw_bus_lock rmw_bus_lock_chk #(.CYC_W(CYC_W), .LOCK_SPAN(LOCK_SPAN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_class   (op_class),
  .cyc_idx    (cyc_idx),
  .cyc_total  (cyc_total),
  .bus_rd     (bus_rd),
  .irq_entry  (irq_entry),
  .mem_lock_n (mem_lock_n)
);

// File: tb/rmw_bus_lock_test.sv
module rmw_bus_lock_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 54;

  logic       clk;
  logic       rst_n;
  logic [2:0] op_class;
  logic [3:0] cyc_idx;
  logic [3:0] cyc_total;
  logic       bus_rd;
  logic       irq_entry;
  logic       mem_lock_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  rmw_bus_lock uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_class   (op_class),
    .cyc_idx    (cyc_idx),
    .cyc_total  (cyc_total),
    .bus_rd     (bus_rd),
    .irq_entry  (irq_entry),
    .mem_lock_n (mem_lock_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {req, class, idx, total, rd, irq, expected lock_n after the edge}
  localparam logic [17:0] VEC [NV] = '{
    // R3 memory shift, 5 cycles: tail 2..4 locked
    {4'd3,3'd2,4'd0,4'd5,1'b1,1'b0,1'b1}, {4'd3,3'd2,4'd1,4'd5,1'b1,1'b0,1'b1},
    {4'd3,3'd2,4'd2,4'd5,1'b1,1'b0,1'b0}, {4'd3,3'd2,4'd3,4'd5,1'b0,1'b0,1'b0},
    {4'd3,3'd2,4'd4,4'd5,1'b0,1'b0,1'b0},
    // R6 release on next instruction
    {4'd6,3'd0,4'd0,4'd2,1'b1,1'b0,1'b1}, {4'd6,3'd0,4'd1,4'd2,1'b1,1'b0,1'b1},
    // R4 accumulator form
    {4'd4,3'd1,4'd0,4'd5,1'b1,1'b0,1'b1}, {4'd4,3'd1,4'd1,4'd5,1'b1,1'b0,1'b1},
    {4'd4,3'd1,4'd2,4'd5,1'b1,1'b0,1'b1}, {4'd4,3'd1,4'd3,4'd5,1'b0,1'b0,1'b1},
    {4'd4,3'd1,4'd4,4'd5,1'b0,1'b0,1'b1},
    // R3 memory inc/dec, 6 cycles: tail 3..5
    {4'd3,3'd3,4'd0,4'd6,1'b1,1'b0,1'b1}, {4'd3,3'd3,4'd1,4'd6,1'b1,1'b0,1'b1},
    {4'd3,3'd3,4'd2,4'd6,1'b1,1'b0,1'b1}, {4'd3,3'd3,4'd3,4'd6,1'b1,1'b0,1'b0},
    {4'd3,3'd3,4'd4,4'd6,1'b0,1'b0,1'b0}, {4'd3,3'd3,4'd5,4'd6,1'b0,1'b0,1'b0},
    // R3 test-bits, then R6 back-to-back set/clear-bit
    {4'd3,3'd4,4'd0,4'd5,1'b1,1'b0,1'b1}, {4'd3,3'd4,4'd1,4'd5,1'b1,1'b0,1'b1},
    {4'd3,3'd4,4'd2,4'd5,1'b1,1'b0,1'b0}, {4'd3,3'd4,4'd3,4'd5,1'b0,1'b0,1'b0},
    {4'd3,3'd4,4'd4,4'd5,1'b0,1'b0,1'b0},
    {4'd6,3'd5,4'd0,4'd5,1'b1,1'b0,1'b1}, {4'd6,3'd5,4'd1,4'd5,1'b1,1'b0,1'b1},
    {4'd6,3'd5,4'd2,4'd5,1'b1,1'b0,1'b0}, {4'd6,3'd5,4'd3,4'd5,1'b0,1'b0,1'b0},
    {4'd6,3'd5,4'd4,4'd5,1'b0,1'b0,1'b0},
    // R5 window opens on a write: no lock
    {4'd5,3'd2,4'd0,4'd5,1'b1,1'b0,1'b1}, {4'd5,3'd2,4'd1,4'd5,1'b1,1'b0,1'b1},
    {4'd5,3'd2,4'd2,4'd5,1'b0,1'b0,1'b1}, {4'd5,3'd2,4'd3,4'd5,1'b0,1'b0,1'b1},
    {4'd5,3'd2,4'd4,4'd5,1'b0,1'b0,1'b1},
    // R4 reserved class 7
    {4'd4,3'd7,4'd0,4'd5,1'b1,1'b0,1'b1}, {4'd4,3'd7,4'd1,4'd5,1'b1,1'b0,1'b1},
    {4'd4,3'd7,4'd2,4'd5,1'b1,1'b0,1'b1}, {4'd4,3'd7,4'd3,4'd5,1'b0,1'b0,1'b1},
    {4'd4,3'd7,4'd4,4'd5,1'b0,1'b0,1'b1},
    // R8 three-cycle instruction
    {4'd8,3'd2,4'd0,4'd3,1'b1,1'b0,1'b1}, {4'd8,3'd2,4'd1,4'd3,1'b1,1'b0,1'b1},
    {4'd8,3'd2,4'd2,4'd3,1'b0,1'b0,1'b1},
    // R7 interrupt entry in mid-window
    {4'd7,3'd2,4'd0,4'd5,1'b1,1'b0,1'b1}, {4'd7,3'd2,4'd1,4'd5,1'b1,1'b0,1'b1},
    {4'd7,3'd2,4'd2,4'd5,1'b1,1'b0,1'b0}, {4'd7,3'd2,4'd3,4'd5,1'b0,1'b1,1'b1},
    {4'd7,3'd2,4'd4,4'd5,1'b0,1'b0,1'b1},
    // R7 interrupt entry at window start
    {4'd7,3'd3,4'd0,4'd6,1'b1,1'b0,1'b1}, {4'd7,3'd3,4'd1,4'd6,1'b1,1'b0,1'b1},
    {4'd7,3'd3,4'd2,4'd6,1'b1,1'b0,1'b1}, {4'd7,3'd3,4'd3,4'd6,1'b1,1'b1,1'b1},
    {4'd7,3'd3,4'd4,4'd6,1'b0,1'b0,1'b1}, {4'd7,3'd3,4'd5,4'd6,1'b0,1'b0,1'b1},
    // R6 idle afterwards
    {4'd6,3'd0,4'd0,4'd2,1'b1,1'b0,1'b1}, {4'd6,3'd0,4'd1,4'd2,1'b1,1'b0,1'b1}
  };

  task automatic check(input int req, input logic exp, input string what);
    checks++;
    if (mem_lock_n !== exp) begin
      fails++;
      $display("FAIL R%0d %s: mem_lock_n=%b expected=%b", req, what, mem_lock_n, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [3:0] i, input logic [3:0] t,
                       input logic rd, input logic irq);
    op_class  = c;
    cyc_idx   = i;
    cyc_total = t;
    bus_rd    = rd;
    irq_entry = irq;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b1;
    drive(3'd0, 4'd0, 4'd2, 1'b1, 1'b0);
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(1, 1'b1, "held in reset");        // R1
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, 1'b1, "after release");        // R1

    for (int n = 0; n < NV; n++) begin
      drive(VEC[n][13:11], VEC[n][10:7], VEC[n][6:3], VEC[n][2], VEC[n][1]);
      @(negedge clk);
      check(int'(VEC[n][17:14]), VEC[n][0], $sformatf("vector %0d", n));  // R2 latency
    end

    // R1: asynchronous drop in the middle of a locked window
    drive(3'd2, 4'd0, 4'd5, 1'b1, 1'b0); @(negedge clk);
    drive(3'd2, 4'd1, 4'd5, 1'b1, 1'b0); @(negedge clk);
    drive(3'd2, 4'd2, 4'd5, 1'b1, 1'b0); @(negedge clk);
    check(3, 1'b0, "lock open before reset");  // R3
    drive(3'd2, 4'd3, 4'd5, 1'b0, 1'b0);
    #1 rst_n = 1'b0;
    #1 check(1, 1'b1, "async drop on reset");  // R1
    @(negedge clk);
    drive(3'd0, 4'd0, 4'd2, 1'b1, 1'b0);
    rst_n = 1'b1;
    // R1: window start presented while the synchronizer is still releasing
    drive(3'd2, 4'd2, 4'd5, 1'b1, 1'b0);
    @(negedge clk);
    check(1, 1'b1, "sync release stage 1");    // R1
    drive(3'd2, 4'd3, 4'd5, 1'b0, 1'b0);
    @(negedge clk);
    check(1, 1'b1, "sync release stage 2");    // R1
    drive(3'd0, 4'd0, 4'd2, 1'b1, 1'b0);
    @(negedge clk);
    check(6, 1'b1, "idle after release");      // R6

    // R2/R3: normal operation resumes
    drive(3'd5, 4'd0, 4'd5, 1'b1, 1'b0); @(negedge clk);
    drive(3'd5, 4'd1, 4'd5, 1'b1, 1'b0); @(negedge clk);
    check(2, 1'b1, "before tail");             // R2
    drive(3'd5, 4'd2, 4'd5, 1'b1, 1'b0); @(negedge clk);
    check(3, 1'b0, "tail read locked");        // R3
    drive(3'd5, 4'd3, 4'd5, 1'b0, 1'b0); @(negedge clk);
    check(9, 1'b0, "write after read held");   // R9
    drive(3'd5, 4'd4, 4'd5, 1'b0, 1'b0); @(negedge clk);
    check(6, 1'b0, "final write held");        // R6
    drive(3'd0, 4'd0, 4'd2, 1'b1, 1'b0); @(negedge clk);
    check(6, 1'b1, "released at boundary");    // R6

    finish_run();
  end

endmodule